// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit serial successive-approximation converter that sits in front of an input multiplexer with up to eight inputs. A host pulls the active-low select low, then clocks a serial word into the data input. The block waits for the first 1, which is the start marker. It then shifts in the channel-configuration field and decodes it into positive and negative multiplexer selections. After that it runs a binary search against an external comparator, using a trial code that it presents to the external DAC.

Each comparator decision appears on the serial output as soon as it is made, most significant bit first. The stored result is then replayed least significant bit first. In the build without a shift-enable pin the replay follows the first stream automatically. In the build with one, the host paces the replay. A busy flag marks the conversion window. The data output is paired with a drive-enable so that the pad can be tri-stated.

Top module: `sar_serial_engine`

## Requirements
- R1: While csN is high every register is cleared: doDrive and busy are 0, trialCode is 0, and the channel outputs are 0. Raising csN has this effect at any moment.
- R2: serIn is sampled on rising clk edges. Sampled zeros before the first sampled 1 have no effect. That first 1 is the start marker.
- R3: The four bits sampled after the start marker are, in order, mode, odd, sel1 and sel0. Mode 1 selects single-ended operation: posChan = {sel1, sel0, odd}, negIsCom = 1 and negChan = 0.
- R4: Mode 0 selects a differential adjacent pair: posChan = {sel1, sel0, odd}, negChan = {sel1, sel0, ~odd} and negIsCom = 0.
- R5: On the falling edge after the rising edge that samples sel0, busy and doDrive go to 1, doBit drives 0 and trialCode becomes 8'h80. This settling slot lasts exactly one clock.
- R6: On each of the next 8 falling edges, compHi is sampled. Its value is kept in the bit under trial, driven on doBit, and the next lower bit becomes the new trial bit in trialCode. The decisions are produced from the MSB down to the LSB.
- R7: With compHi = (analog level >= trialCode), the 8 decisions equal the analog level. A comparator that stays low yields all zeros.
- R8: busy falls on the falling edge one clock after the LSB decision.
- R9: In the build without shift-enable (HAS_SHIFT_EN = 0), bits 1 to 7 of the result follow the LSB on successive falling edges. After them doBit stays 0 until csN rises. shiftEnN has no effect in this build.
- R10: In the build with shift-enable, the LSB stays on doBit while shiftEnN is high after the conversion. Each falling edge with shiftEnN low moves the replay one bit further toward bit 7, and then to 0.
- R11: serIn has no effect from the settling slot until csN rises. In particular, no new start marker is taken.
- R12: A csN rise at any point ends the transaction and releases doDrive. The next transaction runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; serIn is taken on the rising edge, everything else moves on the falling edge |
| csN | input | 1 | Active-low select; high clears the block asynchronously |
| serIn | input | 1 | Serial input carrying the start marker and the configuration bits |
| shiftEnN | input | 1 | Active-low replay pacing; used only when HAS_SHIFT_EN = 1 |
| compHi | input | 1 | Comparator decision: 1 when the selected input is at or above the DAC level |
| doBit | output | 1 | Serial data output value |
| doDrive | output | 1 | Output enable for doBit; 0 means high impedance |
| busy | output | 1 | High from the settling slot until one clock after the LSB decision |
| trialCode | output | RES_W | Code for the external DAC during the search |
| posChan | output | SEL_W+1 | Positive multiplexer input |
| negChan | output | SEL_W+1 | Negative multiplexer input in differential mode, 0 otherwise |
| negIsCom | output | 1 | Negative side is the common line (single-ended) |

## Verification
A wrong sequencer count shows up at the ports within one clock. The bit on doBit and the rising or falling edge of busy land one slot early or late, so the reassembled result no longer matches the analog level. A corrupted trial mask or search register shows first on trialCode in the same clock, and then as a wrong result word. A decode error shows on the channel outputs during the settling slot. A replay fault shows within eight clocks as a wrong LSB-first bit, or as a 1 where the output should sit at 0.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    SEQ_HUNT,
    SEQ_ADDR,
    SEQ_CONV,
    SEQ_XMIT
  } seqState_e;

  // strobes from the sequencer to the datapath, valid for one falling edge
  typedef struct packed {
    logic shiftAddr;
    logic beginConv;
    logic sarStep;
    logic lastStep;
    logic outShift;
    logic endBusy;
  } seqStrobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int RES_W        = 8,
  parameter int HAS_SHIFT_EN = 0
) (
  input  logic       clk,
  input  logic       csN,
  input  logic       serIn,
  input  logic       shiftEnN,
  output logic       sampledBit,
  output seqStrobe_t strobe
);

  localparam int SPAN  = (ADDR_W > RES_W) ? ADDR_W : RES_W;
  localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] RES_LAST  = CNT_W'(RES_W - 1);

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic             advance;

  // serial input captured on the rising edge, consumed on the following falling edge
  always_ff @(posedge clk or posedge csN) begin
    if (csN) sampledBit <= 1'b0;
    else     sampledBit <= serIn;
  end

  assign advance = (HAS_SHIFT_EN == 0) || !shiftEnN;

  always_comb begin
    strobe = '0;
    case (state)
      SEQ_ADDR: begin
        strobe.shiftAddr = 1'b1;
        strobe.beginConv = (cnt == ADDR_LAST);
      end
      SEQ_CONV: begin
        strobe.sarStep  = 1'b1;
        strobe.lastStep = (cnt == RES_LAST);
      end
      SEQ_XMIT: begin
        strobe.endBusy  = 1'b1;
        strobe.outShift = advance;
      end
      default: ;
    endcase
  end

  always_ff @(negedge clk or posedge csN) begin
    if (csN) begin
      state <= SEQ_HUNT;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_HUNT: if (sampledBit) begin
          state <= SEQ_ADDR;
          cnt   <= '0;
        end
        SEQ_ADDR: if (cnt == ADDR_LAST) begin
          state <= SEQ_CONV;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        SEQ_CONV: if (cnt == RES_LAST) begin
          state <= SEQ_XMIT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: ;
      endcase
    end
  end

  // R2: a sampled 1 while hunting always leads into the address phase
  a_r2_start_taken: assert property (@(negedge clk) disable iff (csN)
    (state == SEQ_HUNT && sampledBit) |=> (state == SEQ_ADDR));

  // R11: once past hunting, serIn can never restart the sequence
  a_r11_no_rehunt: assert property (@(negedge clk) disable iff (csN)
    (state != SEQ_HUNT) |=> (state != SEQ_HUNT));

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             csN,
  input  seqStrobe_t       strobe,
  input  logic             sampledBit,
  input  logic             compHi,
  output logic             doBit,
  output logic             doDrive,
  output logic             busy,
  output logic [RES_W-1:0] trialCode,
  output logic [SEL_W:0]   posChan,
  output logic [SEL_W:0]   negChan,
  output logic             negIsCom
);

  localparam int ADDR_W = SEL_W + 2;
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [ADDR_W-2:0]  addrReg;
  logic [ADDR_W-1:0]  fullAddr;
  logic               modeSingle;
  logic               oddBit;
  logic [SEL_W-1:0]   selBits;
  logic [RES_W-1:0]   mask;
  logic [RES_W-1:0]   outBuf;
  logic [RES_W-1:0]   stepNext;
  logic [RES_W-1:0]   finalCode;

  assign fullAddr   = {addrReg, sampledBit};
  assign modeSingle = fullAddr[ADDR_W-1];
  assign oddBit     = fullAddr[ADDR_W-2];
  assign selBits    = fullAddr[SEL_W-1:0];

  assign stepNext  = (trialCode & ~mask) | (compHi ? mask : '0) | (mask >> 1);
  assign finalCode = {trialCode[RES_W-1:1], compHi};

  always_ff @(negedge clk or posedge csN) begin
    if (csN) begin
      addrReg   <= '0;
      posChan   <= '0;
      negChan   <= '0;
      negIsCom  <= 1'b0;
      trialCode <= '0;
      mask      <= '0;
      outBuf    <= '0;
      busy      <= 1'b0;
      doDrive   <= 1'b0;
      doBit     <= 1'b0;
    end else begin
      if (strobe.shiftAddr) addrReg <= {addrReg[ADDR_W-3:0], sampledBit};
      if (strobe.beginConv) begin
        posChan   <= {selBits, oddBit};
        negChan   <= modeSingle ? '0 : {selBits, ~oddBit};
        negIsCom  <= modeSingle;
        trialCode <= TOP_BIT;
        mask      <= TOP_BIT;
        busy      <= 1'b1;
        doDrive   <= 1'b1;
        doBit     <= 1'b0;
      end
      if (strobe.sarStep) begin
        trialCode <= stepNext;
        mask      <= mask >> 1;
        doBit     <= compHi;
      end
      if (strobe.lastStep) outBuf <= finalCode >> 1;
      if (strobe.endBusy)  busy   <= 1'b0;
      if (strobe.outShift) begin
        doBit  <= outBuf[0];
        outBuf <= outBuf >> 1;
      end
    end
  end

  // R5: the settling slot drives a zero with busy raised
  a_r5_settle_slot: assert property (@(negedge clk) disable iff (csN)
    strobe.beginConv |=> (doDrive && busy && !doBit));

  // R6: at most one trial bit is pending
  a_r6_mask_single: assert property (@(negedge clk) disable iff (csN)
    $onehot0(mask));

  // R6: the sequencer's last step lines up with the datapath's LSB trial
  a_r6_lsb_last: assert property (@(negedge clk) disable iff (csN)
    strobe.lastStep |-> mask[0]);

  // R8: busy survives the LSB decision by one clock, then drops
  a_r8_busy_tail: assert property (@(negedge clk) disable iff (csN)
    strobe.lastStep |=> busy);
  a_r8_busy_drop: assert property (@(negedge clk) disable iff (csN)
    strobe.endBusy |=> !busy);

  // R12: drive is only released by csN
  a_r12_drive_held: assert property (@(negedge clk) disable iff (csN)
    doDrive |=> doDrive);

  // R9: an exhausted replay parks the output low
  a_r9_park_low: assert property (@(negedge clk) disable iff (csN)
    (strobe.outShift && outBuf == '0) |=> !doBit);

endmodule

// File: rtl/sar_serial_engine.sv
module sar_serial_engine
  import sar_pkg::*;
#(
  parameter int SEL_W        = 2,
  parameter int RES_W        = 8,
  parameter int HAS_SHIFT_EN = 0
) (
  input  logic             clk,
  input  logic             csN,
  input  logic             serIn,
  input  logic             shiftEnN,
  input  logic             compHi,
  output logic             doBit,
  output logic             doDrive,
  output logic             busy,
  output logic [RES_W-1:0] trialCode,
  output logic [SEL_W:0]   posChan,
  output logic [SEL_W:0]   negChan,
  output logic             negIsCom
);

  localparam int ADDR_W = SEL_W + 2;

  seqStrobe_t strobe;
  logic       sampledBit;

  sar_seq_ctrl #(
    .ADDR_W      (ADDR_W),
    .RES_W       (RES_W),
    .HAS_SHIFT_EN(HAS_SHIFT_EN)
  ) uCtrl (
    .clk       (clk),
    .csN       (csN),
    .serIn     (serIn),
    .shiftEnN  (shiftEnN),
    .sampledBit(sampledBit),
    .strobe    (strobe)
  );

  sar_datapath #(
    .SEL_W(SEL_W),
    .RES_W(RES_W)
  ) uPath (
    .clk       (clk),
    .csN       (csN),
    .strobe    (strobe),
    .sampledBit(sampledBit),
    .compHi    (compHi),
    .doBit     (doBit),
    .doDrive   (doDrive),
    .busy      (busy),
    .trialCode (trialCode),
    .posChan   (posChan),
    .negChan   (negChan),
    .negIsCom  (negIsCom)
  );

endmodule

// File: tb/tb_sar_serial_engine.sv
`timescale 1ns/1ps
module tb_sar_serial_engine;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic csN = 1'b1, serIn = 1'b0, seN = 1'b1;
  int   vin = 0;

  logic       doA, drvA, busyA, comA, compA;
  logic [7:0] trialA;
  logic [2:0] posA, negA;
  logic       doB, drvB, busyB, comB, compB;
  logic [7:0] trialB;
  logic [2:0] posB, negB;

  assign compA = (vin >= int'(trialA));
  assign compB = (vin >= int'(trialB));

  sar_serial_engine #(.SEL_W(2), .RES_W(8), .HAS_SHIFT_EN(0)) dut (
    .clk(clk), .csN(csN), .serIn(serIn), .shiftEnN(seN), .compHi(compA),
    .doBit(doA), .doDrive(drvA), .busy(busyA), .trialCode(trialA),
    .posChan(posA), .negChan(negA), .negIsCom(comA));

  sar_serial_engine #(.SEL_W(2), .RES_W(8), .HAS_SHIFT_EN(1)) dutSe (
    .clk(clk), .csN(csN), .serIn(serIn), .shiftEnN(seN), .compHi(compB),
    .doBit(doB), .doDrive(drvB), .busy(busyB), .trialCode(trialB),
    .posChan(posB), .negChan(negB), .negIsCom(comB));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic samp();
    @(posedge clk);
    #2;
  endtask

  function automatic int trialAt(input int v, input int k);
    int keep = (v & ~((1 << (8 - k)) - 1)) & 255;
    return keep | (1 << (7 - k));
  endfunction

  task automatic runConv(input int v, input int addr, input int lead, input int h, input int diAfter);
    logic [7:0] vb = v[7:0];
    logic [7:0] word = '0;
    int expB;
    vin = v;
    csN = 1'b0; serIn = 1'b0; seN = 1'b1;
    for (int i = 0; i < lead; i++) begin
      samp();
      chk("R2", {30'd0, drvA, busyA}, 32'd0);
      #3;
    end
    serIn = 1'b1;
    for (int n = 1; n <= 26; n++) begin
      samp();
      if (n <= 5) begin
        chk("R2", {29'd0, drvA, busyA, drvB}, 32'd0);
      end else begin
        chk("R12", 32'(drvA), 32'd1);
        chk("R8", {30'd0, busyA, busyB}, (n <= 14) ? 32'd3 : 32'd0);
      end
      if (n == 6) begin
        chk("R5", {30'd0, doA, doB}, 32'd0);
        if (addr[3]) begin
          chk("R3", {25'd0, posA, negA, comA}, {25'd0, addr[1:0], addr[2], 3'd0, 1'b1});
        end else begin
          chk("R4", {25'd0, posA, negA, comA}, {25'd0, addr[1:0], addr[2], addr[1:0], ~addr[2], 1'b0});
        end
      end
      if (n >= 6 && n <= 13) chk("R6", 32'(trialA), 32'(trialAt(v, n - 6)));
      if (n >= 7 && n <= 14) begin
        chk("R6", {30'd0, doA, doB}, {30'd0, vb[14-n], vb[14-n]});
        word[14-n] = doA;
      end
      if (n == 14) chk("R7", 32'(word), 32'(v));
      if (n >= 15) begin
        chk("R9", 32'(doA), (n - 14 <= 7) ? 32'(vb[n-14]) : 32'd0);
        chk("R11", 32'(busyA), 32'd0);
      end
      if (n >= 14) begin
        expB = n - 14 - h;
        chk("R10", 32'(doB), (expB <= 0) ? 32'(vb[0]) : (expB <= 7) ? 32'(vb[expB]) : 32'd0);
      end
      #3;
      if (n <= 4) serIn = addr[4-n];
      else        serIn = (diAfter != 0) ? n[0] : 1'b0;
      seN = (n >= 14 + h) ? 1'b0 : 1'b1;
    end
    csN = 1'b1; serIn = 1'b1;
    samp();
    chk("R1", {27'd0, drvA, busyA, drvB, busyB, comA}, 32'd0);
    chk("R1", {16'd0, trialA, 5'd0, posA}, 32'd0);
    #3;
    serIn = 1'b0;
  endtask

  task automatic runAbort(input int v, input int addr, input int k);
    vin = v;
    csN = 1'b0; serIn = 1'b1; seN = 1'b0;
    for (int n = 1; n <= k; n++) begin
      samp();
      #3;
      if (n <= 4) serIn = addr[4-n];
      else        serIn = 1'b0;
    end
    csN = 1'b1; serIn = 1'b1;
    samp();
    chk("R12", {28'd0, drvA, busyA, doA, drvB}, 32'd0);
    chk("R12", 32'(trialA), 32'd0);
    samp();
    chk("R1", {30'd0, busyA, busyB}, 32'd0);
    #3;
    serIn = 1'b0;
  endtask

  initial begin
    samp();
    chk("R1", {29'd0, drvA, busyA, doA}, 32'd0);
    chk("R1", 32'(trialA), 32'd0);
    #3;
    // R7: v = 0 keeps the comparator low for every trial, v = 255 keeps it high
    for (int v = 0; v < 256; v++) runConv(v, v % 16, v % 3, v % 4, v % 2);
    runAbort(8'hA5, 4'b1011, 3);
    runConv(8'h3C, 4'b0110, 0, 1, 1);
    runAbort(8'h5A, 4'b1000, 9);
    runConv(8'hC3, 4'b1111, 2, 2, 0);
    runAbort(8'h81, 4'b0001, 17);
    runConv(8'h7E, 4'b0100, 1, 3, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule